// File: doc/BRIEF.md
# LPC I/O Cycle Sequencer

This block gives a host that has no native I/O space a way to run Low Pin Count I/O read and write cycles through a small memory-mapped register window. Software sets up a burst in three registers: a cycle count, a command word and a 16-bit target port. For a write burst, software also pushes data bytes into a write queue. Setting the start bit then launches the burst.

The sequencer runs one single-byte LPC I/O cycle per count. Each cycle uses either the same port or a port that rises by one after every cycle. Bytes returned by read cycles collect in a read queue, which software drains one byte per register read. On completion the block shows idle and a separate success flag, and it raises a write-one-to-clear interrupt flag. A target may stretch each cycle with wait nibbles up to a limit. It may also answer with an error nibble. Either case ends the burst early, with the success flag clear.

Top module: `lpc_io_seq`

## Requirements
- R1: After reset, the status register (offset 0x04) reads 0x1, the interrupt register (offset 0x08) reads 0x0, `irq` is low, `lframe_n` is high and `lad_oe` is low.
- R2: A write with bit 0 set to offset 0x00 starts a burst only when the block is idle and the length field (offset 0x10, bits [4:0]) holds 1 to 16. Status bit 0 reads 0 while a burst runs. A start with length 0 or above 16 drives no cycle and leaves the status register unchanged.
- R3: Each cycle drives, one nibble per clock on `lad_o` with `lad_oe` high: nibble 0000 with `lframe_n` low, then 0000 for a read or 0010 for a write, then the four port nibbles most significant first, then for a write the data byte low nibble first, then 1111. The next clock releases the bus.
- R4: Command bit 3 (offset 0x14) set keeps every cycle on the programmed port. When it is clear, the port rises by one after each cycle and carries across nibbles. Command bit 0 set selects write, clear selects read.
- R5: Bytes written to offset 0x24 (bits [7:0]) go out in push order on successive write cycles. A write cycle with the queue empty sends 0x00. Bytes left unused when a burst ends are discarded.
- R6: Each read of offset 0x28 returns the oldest byte captured by read cycles in bits [7:0] and removes it. An empty queue reads 0. A newly accepted start empties the queue.
- R7: After the bus turnaround, the block samples `lad_i` once per clock. 0000 means ready and 1010 means error. Any other nibble is a wait. Up to 256 wait nibbles per cycle are tolerated. The 257th wait aborts the burst.
- R8: An error nibble or a wait timeout ends the burst at once. No further cycles are run.
- R9: Status bit 0 is 1 when idle. Status bit 1 is 1 only when the last burst completed all its cycles. It is cleared by an accepted start.
- R10: Interrupt register bit 1 is set at the end of every burst and is cleared by writing 1 to it. Writing 0 to it has no effect. Bit 0 is a read/write enable, and `irq` is high when both bits are 1.
- R11: While a burst runs, writes to offsets 0x00, 0x10, 0x14 and 0x20 are ignored. Read-back of the length, command and port registers is unchanged, and the running burst keeps its programmed ports.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, shared by the register bus and the LPC bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the read queue at 0x28) |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Completion interrupt (enable AND flag) |
| lframe_n | output | 1 | Active-low frame marker |
| lad_o | output | 4 | Nibble driven onto the LAD bus |
| lad_oe | output | 1 | Drive enable for `lad_o` |
| lad_i | input | 4 | Nibble sampled from the LAD bus |

## Verification
The hardest case to reach from the ports is the wait boundary. A cycle must succeed after exactly 256 wait nibbles, and the same cycle must fail after one more. The bench target counts the nibbles it returns after it sees the host release the bus, and it is set to emit 256 and then 300 waits. A second hard case is an error in the middle of a burst. The target is set to answer a chosen cycle with an error nibble, and the bench confirms that no later cycle appears on the pins.

// File: rtl/lpc_seq_pkg.sv
package lpc_seq_pkg;

  typedef enum logic [3:0] {
    CS_IDLE, CS_START, CS_CTDIR, CS_ADDR, CS_WDATA,
    CS_TAR_H0, CS_TAR_H1, CS_SYNC, CS_RDATA, CS_TAR_T0, CS_TAR_T1
  } cyc_state_e;

  localparam logic [3:0] NIB_START = 4'h0;
  localparam logic [3:0] NIB_READY = 4'h0;
  localparam logic [3:0] NIB_ERROR = 4'hA;
  localparam logic [3:0] NIB_IDLE  = 4'hF;

  localparam logic [5:0] OFS_START  = 6'h00;
  localparam logic [5:0] OFS_STATUS = 6'h04;
  localparam logic [5:0] OFS_IRQ    = 6'h08;
  localparam logic [5:0] OFS_LEN    = 6'h10;
  localparam logic [5:0] OFS_CMD    = 6'h14;
  localparam logic [5:0] OFS_ADDR   = 6'h20;
  localparam logic [5:0] OFS_WDATA  = 6'h24;
  localparam logic [5:0] OFS_RDATA  = 6'h28;

  // cycle type / direction nibble: I/O type is 00, bit 1 is the direction
  function automatic logic [3:0] ctdir_nibble(input logic is_write);
    return {2'b00, is_write, 1'b0};
  endfunction

endpackage

// File: rtl/byte_fifo.sv
// Show-ahead FIFO; DEPTH must be a power of two.
module byte_fifo #(
  parameter  int W     = 8,
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic [AW:0]  count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, do_push, do_pop;

  assign full    = (count == (AW+1)'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= din;
  end
endmodule

// File: rtl/lpc_cycle_drv.sv
// Runs one single-byte LPC I/O cycle per go pulse.
module lpc_cycle_drv import lpc_seq_pkg::*; #(
  parameter  int ADDR_W   = 16,
  parameter  int MAX_WAIT = 256,
  localparam int NA       = ADDR_W / 4,
  localparam int NW       = (NA > 1) ? $clog2(NA) : 1,
  localparam int WCW      = $clog2(MAX_WAIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic [3:0]        lad_i,
  output logic              lframe_n,
  output logic [3:0]        lad_o,
  output logic              lad_oe,
  output logic              done,
  output logic              ok,
  output logic [7:0]        rbyte,
  output logic [WCW-1:0]    wait_cnt
);
  cyc_state_e        st;
  logic [NW-1:0]     nib;
  logic              dhi, wr_l;
  logic [ADDR_W-1:0] addr_l;
  logic [7:0]        wd_l;

  // most significant nibble first
  function automatic logic [3:0] port_nibble(input logic [ADDR_W-1:0] a, input logic [NW-1:0] i);
    logic [ADDR_W-1:0] sh;
    sh = a >> (4 * (NA - 1 - int'(i)));
    return sh[3:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= CS_IDLE; nib <= '0; dhi <= 1'b0; wait_cnt <= '0; wr_l <= 1'b0;
      addr_l <= '0; wd_l <= '0; rbyte <= '0; done <= 1'b0; ok <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        CS_IDLE: if (go) begin
          st <= CS_START; wr_l <= write; addr_l <= addr; wd_l <= wdata;
        end
        CS_START: st <= CS_CTDIR;
        CS_CTDIR: begin st <= CS_ADDR; nib <= '0; end
        CS_ADDR: begin
          nib <= nib + 1'b1;
          dhi <= 1'b0;
          if (nib == NW'(NA - 1)) st <= wr_l ? CS_WDATA : CS_TAR_H0;
        end
        CS_WDATA: begin dhi <= 1'b1; if (dhi) st <= CS_TAR_H0; end
        CS_TAR_H0: st <= CS_TAR_H1;
        CS_TAR_H1: begin st <= CS_SYNC; wait_cnt <= '0; end
        CS_SYNC: begin
          if (lad_i == NIB_READY) begin
            st <= wr_l ? CS_TAR_T0 : CS_RDATA; dhi <= 1'b0;
          end else if (lad_i == NIB_ERROR || wait_cnt == WCW'(MAX_WAIT)) begin
            st <= CS_IDLE; done <= 1'b1; ok <= 1'b0;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        CS_RDATA: begin
          dhi <= 1'b1;
          if (!dhi) rbyte[3:0] <= lad_i;
          else begin rbyte[7:4] <= lad_i; st <= CS_TAR_T0; end
        end
        CS_TAR_T0: st <= CS_TAR_T1;
        CS_TAR_T1: begin st <= CS_IDLE; done <= 1'b1; ok <= 1'b1; end
        default: st <= CS_IDLE;
      endcase
    end
  end

  assign lframe_n = (st != CS_START);
  assign lad_oe   = (st == CS_START) || (st == CS_CTDIR) || (st == CS_ADDR) ||
                    (st == CS_WDATA) || (st == CS_TAR_H0);

  always_comb begin
    case (st)
      CS_START: lad_o = NIB_START;
      CS_CTDIR: lad_o = ctdir_nibble(wr_l);
      CS_ADDR:  lad_o = port_nibble(addr_l, nib);
      CS_WDATA: lad_o = dhi ? wd_l[7:4] : wd_l[3:0];
      default:  lad_o = NIB_IDLE;
    endcase
  end
endmodule

// File: rtl/lpc_io_seq.sv
module lpc_io_seq import lpc_seq_pkg::*; #(
  parameter  int ADDR_W     = 16,
  parameter  int FIFO_DEPTH = 16,
  parameter  int MAX_BURST  = 16,
  parameter  int MAX_WAIT   = 256,
  localparam int LW         = $clog2(MAX_BURST + 1),
  localparam int CW         = $clog2(FIFO_DEPTH) + 1,
  localparam int WCW        = $clog2(MAX_WAIT + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [5:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        lframe_n,
  output logic [3:0]  lad_o,
  output logic        lad_oe,
  input  logic [3:0]  lad_i
);
  logic [LW-1:0]     len_q, remain;
  logic              cmd_wr_q, cmd_fix_q, busy_q, ok_q, ien_q, ist_q, issue_q;
  logic [ADDR_W-1:0] addr_q, cur_addr;
  logic              start_acc, burst_end;
  logic              drv_done, drv_ok;
  logic [7:0]        drv_rbyte, wf_head, rf_head;
  logic [WCW-1:0]    drv_wait_cnt;
  logic              wf_empty, rf_empty;
  logic [CW-1:0]     wf_count, rf_count;
  logic              unused_bits;

  assign unused_bits = ^reg_wdata;

  function automatic logic [ADDR_W-1:0] next_port(input logic [ADDR_W-1:0] a, input logic fixed);
    return fixed ? a : a + ADDR_W'(1);
  endfunction

  assign start_acc = reg_wr && (reg_addr == OFS_START) && reg_wdata[0] && !busy_q &&
                     (len_q != '0) && (len_q <= LW'(MAX_BURST));
  assign burst_end = drv_done && (!drv_ok || remain == LW'(1));

  byte_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) wfifo_i (
    .clk(clk), .rst_n(rst_n), .flush(burst_end),
    .push(reg_wr && reg_addr == OFS_WDATA), .din(reg_wdata[7:0]),
    .pop(issue_q && cmd_wr_q), .dout(wf_head), .empty(wf_empty), .count(wf_count));

  byte_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) rfifo_i (
    .clk(clk), .rst_n(rst_n), .flush(start_acc),
    .push(drv_done && drv_ok && !cmd_wr_q), .din(drv_rbyte),
    .pop(reg_rd && reg_addr == OFS_RDATA), .dout(rf_head), .empty(rf_empty), .count(rf_count));

  lpc_cycle_drv #(.ADDR_W(ADDR_W), .MAX_WAIT(MAX_WAIT)) drv_i (
    .clk(clk), .rst_n(rst_n), .go(issue_q), .write(cmd_wr_q), .addr(cur_addr),
    .wdata(wf_empty ? 8'h00 : wf_head), .lad_i(lad_i),
    .lframe_n(lframe_n), .lad_o(lad_o), .lad_oe(lad_oe),
    .done(drv_done), .ok(drv_ok), .rbyte(drv_rbyte), .wait_cnt(drv_wait_cnt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0; cmd_wr_q <= 1'b0; cmd_fix_q <= 1'b0; addr_q <= '0;
      busy_q <= 1'b0; ok_q <= 1'b0; ien_q <= 1'b0; ist_q <= 1'b0;
      issue_q <= 1'b0; remain <= '0; cur_addr <= '0;
    end else begin
      issue_q <= 1'b0;
      if (reg_wr && !busy_q) begin
        case (reg_addr)
          OFS_LEN:  len_q <= reg_wdata[LW-1:0];
          OFS_CMD:  begin cmd_wr_q <= reg_wdata[0]; cmd_fix_q <= reg_wdata[3]; end
          OFS_ADDR: addr_q <= reg_wdata[ADDR_W-1:0];
          default: ;
        endcase
      end
      if (reg_wr && reg_addr == OFS_IRQ) begin
        ien_q <= reg_wdata[0];
        if (reg_wdata[1]) ist_q <= 1'b0;
      end
      if (start_acc) begin
        busy_q <= 1'b1; ok_q <= 1'b0; cur_addr <= addr_q; remain <= len_q; issue_q <= 1'b1;
      end
      if (drv_done) begin
        if (burst_end) begin
          busy_q <= 1'b0; ok_q <= drv_ok; ist_q <= 1'b1;
        end else begin
          remain <= remain - LW'(1);
          cur_addr <= next_port(cur_addr, cmd_fix_q);
          issue_q <= 1'b1;
        end
      end
    end
  end

  assign irq = ien_q & ist_q;

  always_comb begin
    case (reg_addr)
      OFS_STATUS: reg_rdata = {30'b0, ok_q, ~busy_q};
      OFS_IRQ:    reg_rdata = {30'b0, ist_q, ien_q};
      OFS_LEN:    reg_rdata = 32'(len_q);
      OFS_CMD:    reg_rdata = {28'b0, cmd_fix_q, 2'b00, cmd_wr_q};
      OFS_ADDR:   reg_rdata = 32'(addr_q);
      OFS_RDATA:  reg_rdata = rf_empty ? 32'h0 : {24'b0, rf_head};
      default:    reg_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/lpc_io_seq_chk.sv
module lpc_io_seq_chk #(
  parameter  int DEPTH    = 16,
  parameter  int MAX_WAIT = 256,
  parameter  int ADDR_W   = 16,
  localparam int CW       = $clog2(DEPTH) + 1,
  localparam int WCW      = $clog2(MAX_WAIT + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lframe_n,
  input logic              lad_oe,
  input logic [3:0]        lad_o,
  input logic              busy,
  input logic              start_acc,
  input logic              burst_end,
  input logic              int_st,
  input logic [WCW-1:0]    wait_cnt,
  input logic [CW-1:0]     rf_count,
  input logic [CW-1:0]     wf_count,
  input logic [ADDR_W-1:0] addr_q
);
  assert_frame_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !lframe_n |-> (lad_oe && lad_o == 4'h0));
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> busy);
  assert_end_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |=> (int_st && !busy));
  assert_wait_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= WCW'(MAX_WAIT));
  assert_rfifo_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_count <= CW'(DEPTH));
  assert_wfifo_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wf_count <= CW'(DEPTH));
  assert_port_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(addr_q));
endmodule

bind lpc_io_seq lpc_io_seq_chk #(.DEPTH(FIFO_DEPTH), .MAX_WAIT(MAX_WAIT), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .lframe_n(lframe_n), .lad_oe(lad_oe), .lad_o(lad_o),
  .busy(busy_q), .start_acc(start_acc), .burst_end(burst_end), .int_st(ist_q),
  .wait_cnt(drv_wait_cnt), .rf_count(rf_count), .wf_count(wf_count), .addr_q(addr_q));

// File: tb/lpc_io_seq_tb_top.sv
`timescale 1ns/1ps
module lpc_io_seq_tb_top;
  localparam logic [5:0] A_GO = 6'h00, A_STAT = 6'h04, A_INT = 6'h08, A_LEN = 6'h10,
                         A_CMD = 6'h14, A_PORT = 6'h20, A_PUSH = 6'h24, A_POP = 6'h28;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq, lframe_n, lad_oe;
  logic [3:0] lad_o, lad_i = 4'hF;

  always #4 clk = ~clk;

  lpc_io_seq dut_i (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .lframe_n(lframe_n), .lad_o(lad_o), .lad_oe(lad_oe), .lad_i(lad_i));

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural LPC I/O target ----------------
  logic [15:0] log_a[$];
  logic        log_w[$];
  logic [7:0]  log_d[$];
  logic        log_e[$];
  int ph = 0, n = 0, waits_left = 0, cfg_waits = 0, cfg_err_at = -1, cyc_idx = 0;
  logic        t_wr = 1'b0;
  logic [15:0] t_a = '0;
  logic [7:0]  t_d = '0, rd_next = 8'h50;

  always @(negedge clk) begin
    if (rst_n && !lframe_n && lad_oe && lad_o == 4'h0) begin
      ph = 1; lad_i = 4'hF;
    end else begin
      case (ph)
        1: begin t_wr = lad_o[1]; ph = 2; n = 0; end
        2: begin t_a = {t_a[11:0], lad_o}; n++; if (n == 4) begin ph = t_wr ? 3 : 4; n = 0; end end
        3: begin
          if (n == 0) begin t_d[3:0] = lad_o; n = 1; end
          else begin t_d[7:4] = lad_o; ph = 4; n = 0; end
        end
        4: begin n++; if (n == 2) begin ph = 5; waits_left = cfg_waits; end end
        5: begin
          if (waits_left > 0) begin lad_i = 4'h6; waits_left--; end
          else if (cyc_idx == cfg_err_at) begin
            lad_i = 4'hA;
            log_a.push_back(t_a); log_w.push_back(t_wr); log_d.push_back(t_d); log_e.push_back(1'b1);
            cyc_idx++; ph = 0;
          end else begin
            lad_i = 4'h0;
            if (!t_wr) begin t_d = rd_next; rd_next++; end
            log_a.push_back(t_a); log_w.push_back(t_wr); log_d.push_back(t_d); log_e.push_back(1'b0);
            cyc_idx++; ph = t_wr ? 7 : 6; n = 0;
          end
        end
        6: begin
          if (n == 0) begin lad_i = t_d[3:0]; n = 1; end
          else begin lad_i = t_d[7:4]; ph = 7; n = 0; end
        end
        7: begin lad_i = 4'hF; n++; if (n == 2) ph = 0; end
        default: lad_i = 4'hF;
      endcase
    end
  end

  // ---------------- register access ----------------
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    int t = 0;
    do begin rd(A_STAT, s); t++; end while (!s[0] && t < 20000);
    if (!s[0]) chk("R9 burst never returned idle", s, 32'h1);
  endtask

  task automatic clear_log();
    log_a.delete(); log_w.delete(); log_d.delete(); log_e.delete();
  endtask

  task automatic chk_cyc(input string tag, input int i, input logic [15:0] a,
                         input logic w, input logic [7:0] d, input logic e);
    if (i < log_a.size()) begin
      chk({tag, " port"}, 32'(log_a[i]), 32'(a));
      chk({tag, " dir"},  32'(log_w[i]), 32'(w));
      chk({tag, " data"}, 32'(log_d[i]), 32'(d));
      chk({tag, " err"},  32'(log_e[i]), 32'(e));
    end else chk({tag, " cycle missing"}, 32'(log_a.size()), 32'(i + 1));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
    $finish;
  end

  // ---------------- tests ----------------
  initial begin
    logic [31:0] v;
    logic [7:0] base;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(A_STAT, v); chk("R1 status", v, 32'h1);
    rd(A_INT, v);  chk("R1 int reg", v, 32'h0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 lframe_n", 32'(lframe_n), 1);
    chk("R1 lad_oe", 32'(lad_oe), 0);
    wr(A_INT, 32'h1);

    // R3 R4 R5 incrementing write burst
    clear_log();
    wr(A_LEN, 3); wr(A_CMD, 32'h1); wr(A_PORT, 32'h02E0);
    wr(A_PUSH, 32'h11); wr(A_PUSH, 32'h22); wr(A_PUSH, 32'h33);
    wr(A_GO, 1); wait_idle();
    chk("R4 write burst cycle count", 32'(log_a.size()), 3);
    chk_cyc("R3 wr0", 0, 16'h02E0, 1'b1, 8'h11, 1'b0);
    chk_cyc("R5 wr1", 1, 16'h02E1, 1'b1, 8'h22, 1'b0);
    chk_cyc("R4 wr2", 2, 16'h02E2, 1'b1, 8'h33, 1'b0);
    rd(A_STAT, v); chk("R9 status after success", v, 32'h3);
    rd(A_INT, v);  chk("R10 int flag set", v, 32'h3);
    chk("R10 irq high", 32'(irq), 1);

    // R10 write-one-to-clear
    wr(A_INT, 32'h1); rd(A_INT, v); chk("R10 write 0 keeps flag", v, 32'h3);
    wr(A_INT, 32'h3); rd(A_INT, v); chk("R10 write 1 clears flag", v, 32'h1);
    chk("R10 irq low after clear", 32'(irq), 0);

    // R4 R6 fixed-port read burst
    clear_log(); base = rd_next;
    wr(A_LEN, 4); wr(A_CMD, 32'h8); wr(A_PORT, 32'h00E4);
    wr(A_GO, 1); wait_idle();
    chk("R4 read burst cycle count", 32'(log_a.size()), 4);
    for (int i = 0; i < 4; i++) chk_cyc("R4 fixed rd", i, 16'h00E4, 1'b0, base + 8'(i), 1'b0);
    for (int i = 0; i < 4; i++) begin rd(A_POP, v); chk("R6 pop order", v, 32'(base + 8'(i))); end
    rd(A_POP, v); chk("R6 empty pop", v, 32'h0);

    // R4 increment with carry across nibbles
    clear_log(); base = rd_next;
    wr(A_LEN, 2); wr(A_CMD, 32'h0); wr(A_PORT, 32'h1FFF);
    wr(A_GO, 1); wait_idle();
    chk_cyc("R4 carry rd0", 0, 16'h1FFF, 1'b0, base, 1'b0);
    chk_cyc("R4 carry rd1", 1, 16'h2000, 1'b0, base + 8'd1, 1'b0);

    // R7 R6 exactly 256 waits succeeds; start flushes the two unread bytes
    clear_log(); base = rd_next; cfg_waits = 256;
    wr(A_LEN, 1); wr(A_CMD, 32'h8); wr(A_PORT, 32'h0060);
    wr(A_GO, 1); wait_idle();
    rd(A_STAT, v); chk("R7 256 waits ok", v, 32'h3);
    rd(A_POP, v); chk("R6 flushed at start", v, 32'(base));
    rd(A_POP, v); chk("R6 empty after flush", v, 32'h0);

    // R7 R8 wait timeout
    clear_log(); cfg_waits = 300; cfg_err_at = cyc_idx;
    wr(A_INT, 32'h3);
    wr(A_GO, 1); wait_idle();
    rd(A_STAT, v); chk("R7 timeout fails", v, 32'h1);
    rd(A_INT, v); chk("R10 flag on failure", v, 32'h3);
    repeat (400) @(posedge clk);
    cfg_waits = 0; cfg_err_at = -1;
    wr(A_INT, 32'h3);

    // R5 leftover bytes discarded, empty queue sends 0x00
    clear_log();
    wr(A_LEN, 1); wr(A_CMD, 32'h1); wr(A_PORT, 32'h0080);
    wr(A_PUSH, 32'hAA); wr(A_PUSH, 32'hBB); wr(A_PUSH, 32'hCC);
    wr(A_GO, 1); wait_idle();
    wr(A_PUSH, 32'hDD); wr(A_GO, 1); wait_idle();
    wr(A_GO, 1); wait_idle();
    chk_cyc("R5 first byte", 0, 16'h0080, 1'b1, 8'hAA, 1'b0);
    chk_cyc("R5 leftovers dropped", 1, 16'h0080, 1'b1, 8'hDD, 1'b0);
    chk_cyc("R5 empty sends zero", 2, 16'h0080, 1'b1, 8'h00, 1'b0);

    // R8 error nibble mid-burst
    clear_log(); cfg_err_at = cyc_idx + 1;
    wr(A_LEN, 4); wr(A_CMD, 32'h1); wr(A_PORT, 32'h0300);
    for (int i = 0; i < 4; i++) wr(A_PUSH, 32'(8'hC0 + 8'(i)));
    wr(A_GO, 1); wait_idle();
    repeat (50) @(posedge clk);
    chk("R8 no cycles after error", 32'(log_a.size()), 2);
    chk_cyc("R8 first ok", 0, 16'h0300, 1'b1, 8'hC0, 1'b0);
    chk_cyc("R8 error cycle", 1, 16'h0301, 1'b1, 8'hC1, 1'b1);
    rd(A_STAT, v); chk("R9 status after error", v, 32'h1);
    cfg_err_at = -1;

    // R11 R2 writes ignored while busy
    clear_log(); cfg_waits = 20;
    wr(A_LEN, 2); wr(A_CMD, 32'h8); wr(A_PORT, 32'h0040);
    wr(A_GO, 1);
    rd(A_STAT, v); chk("R2 busy while running", 32'(v[0]), 0);
    wr(A_PORT, 32'h0999); wr(A_LEN, 7); wr(A_CMD, 32'h1); wr(A_GO, 1);
    wait_idle(); repeat (50) @(posedge clk);
    chk("R11 cycle count", 32'(log_a.size()), 2);
    chk_cyc("R11 port kept 0", 0, 16'h0040, 1'b0, log_d.size() > 0 ? log_d[0] : 8'h00, 1'b0);
    chk_cyc("R11 port kept 1", 1, 16'h0040, 1'b0, log_d.size() > 1 ? log_d[1] : 8'h00, 1'b0);
    rd(A_PORT, v); chk("R11 port reg", v, 32'h0040);
    rd(A_LEN, v);  chk("R11 len reg", v, 32'h2);
    rd(A_CMD, v);  chk("R11 cmd reg", v, 32'h8);
    cfg_waits = 0;

    // R2 bad lengths
    clear_log();
    wr(A_LEN, 0); wr(A_GO, 1); repeat (60) @(posedge clk);
    rd(A_STAT, v); chk("R2 len 0 ignored status", v, 32'h3);
    wr(A_LEN, 17); wr(A_GO, 1); repeat (60) @(posedge clk);
    rd(A_STAT, v); chk("R2 len 17 ignored status", v, 32'h3);
    chk("R2 no cycles", 32'(log_a.size()), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule